// File: doc/BRIEF.md
# Pointer Configuration Sequencer

This block sits beside a small signal processor's register file. It owns five memory-pointer registers and one 32-bit configuration register that is shared by all five. Software loads the configuration register with two 16-bit accesses: the address word goes in first and the mode word second. After those two accesses the sequencer is armed. The next access to any pointer register, read or write, does not move data. It copies the whole 32-bit configuration value into a slot that belongs to that pointer and to the direction of the access. The stored slots are presented on a selection port for the transfer engine downstream, which is outside this block.

A pointer access made while the sequencer is not armed behaves in one of two ways. If the read slot of that pointer is programmed (nonzero), the access is mode-driven: it returns zero and writes nothing. Otherwise it is a plain access to a single 16-bit word, and all five pointer indices share that word. A third configuration access made while the sequencer is already armed is reported as an anomaly, and it still overwrites the mode half of the configuration register.

The sequencer has three states:
- `ST_WAIT_ADDR`: the next configuration access uses the address half.
- `ST_WAIT_MODE`: the next configuration access uses the mode half.
- `ST_ARMED`: the next pointer access programs a slot.

It has four transitions:
- T_ADDR (`ST_WAIT_ADDR` → `ST_WAIT_MODE`) on any configuration access.
- T_MODE (`ST_WAIT_MODE` → `ST_ARMED`) on any configuration access.
- T_REARM (`ST_ARMED` → `ST_ARMED`) on a configuration access, which raises the anomaly.
- T_CONSUME (`ST_ARMED` → `ST_WAIT_ADDR`) on any pointer access.

Top module: `ptr_cfg_seq`

## Requirements
- R1: After reset the state is `ST_WAIT_ADDR`, the configuration register, the plain word and every slot hold zero, and `anomaly` is low.
- R2: Index 14 is the configuration register. In `ST_WAIT_ADDR` a write loads bits 31:16 (address) and moves to `ST_WAIT_MODE`. There a write loads bits 15:0 (mode) and moves to `ST_ARMED`.
- R3: A read of index 14 steps the sequence in the same way as a write. `rdata` shows the address half in `ST_WAIT_ADDR` and the mode half in the other two states, in the cycle of the access.
- R4: In `ST_ARMED`, a read of pointer index 8+k (k = 0..4) stores {address, mode} into slot k and returns 0 on `rdata`.
- R5: In `ST_ARMED`, a write of pointer index 8+k stores {address, mode} into slot k+6 and leaves the plain word unchanged.
- R6: A programming access (T_CONSUME) returns the state to `ST_WAIT_ADDR`, so the next configuration access uses the address half again.
- R7: A configuration access in `ST_ARMED` overwrites the mode half and keeps the state. It makes `anomaly` high for exactly the one cycle that follows the access.
- R8: When the sequencer is not armed, an access to pointer index 8+k whose slot k is nonzero returns 0, and a write of this kind leaves the plain word unchanged.
- R9: When the sequencer is not armed and slot k is zero, the access to index 8+k reads or writes one 16-bit word that all five pointer indices share.
- R10: Accesses to indices other than 8..12 and 14 return 0 and change neither the state, the slots nor the plain word.
- R11: `cfg_data` shows slot `cfg_sel` combinationally. Indices 5 and 11..15 show 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 4 | Register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational in the access cycle |
| anomaly | output | 1 | One-cycle pulse after a configuration access made while armed |
| cfg_sel | input | 4 | Slot select for the downstream engine |
| cfg_data | output | 32 | Contents of the selected slot |

## Verification
The access stream mixes plain reads and writes across different pointer indices. This shows whether the five indices really share one word or address separate storage. Configuration accesses are made with both writes and reads, so a sequence that only steps on one direction is caught. Programming accesses are made in both directions to different pointers, and the slot readout then tells read slots apart from write slots, which sit at index plus six. Further patterns cover a third configuration access, a pointer whose read slot is already programmed, and indices outside the map. Together they separate overwrite-with-anomaly, mode-driven silence and true no-effect behaviour. A reset in the middle of the run confirms that the programmed slots are cleared.

// File: rtl/ptr_cfg_pkg.sv
package ptr_cfg_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_ADDR = 2'd0,
        ST_WAIT_MODE = 2'd1,
        ST_ARMED     = 2'd2
    } seq_state_t;

endpackage

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import ptr_cfg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_hit,
    input  logic            ctl_wr,
    input  logic [DW-1:0]   ctl_wdata,
    input  logic            consume,
    output seq_state_t      state_q,
    output logic [2*DW-1:0] ctl_val,
    output logic [DW-1:0]   ctl_rdata,
    output logic            anomaly
);

    seq_state_t    state_d;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] mode_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_ADDR;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_ADDR: if (ctl_hit) state_d = ST_WAIT_MODE;   // T_ADDR
            ST_WAIT_MODE: if (ctl_hit) state_d = ST_ARMED;       // T_MODE
            ST_ARMED:     if (consume) state_d = ST_WAIT_ADDR;   // T_CONSUME
            default:      state_d = ST_WAIT_ADDR;
        endcase
    end

    // outputs and the configuration halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mode_q  <= '0;
            anomaly <= 1'b0;
        end else begin
            anomaly <= ctl_hit && (state_q == ST_ARMED);         // T_REARM
            if (ctl_hit && ctl_wr) begin
                if (state_q == ST_WAIT_ADDR) addr_q <= ctl_wdata;
                else                         mode_q <= ctl_wdata;
            end
        end
    end

    assign ctl_val   = {addr_q, mode_q};
    assign ctl_rdata = (state_q == ST_WAIT_ADDR) ? addr_q : mode_q;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ADDR && ctl_hit) |=> (state_q == ST_WAIT_MODE)); // R2
    AST_MODE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_MODE && ctl_hit) |=> (state_q == ST_ARMED)); // R3
    AST_CONSUME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (state_q == ST_WAIT_ADDR)); // R6
    AST_ANOM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly |-> ($past(state_q) == ST_ARMED && $past(ctl_hit))); // R7
    AST_REARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && ctl_hit) |=> (state_q == ST_ARMED && anomaly)); // R7

endmodule

// File: rtl/cfg_slot_bank.sv
module cfg_slot_bank #(
    parameter int CW    = 32,
    parameter int NSLOT = 11,
    parameter int IDXW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_en,
    input  logic [IDXW-1:0] prog_idx,
    input  logic [CW-1:0]   prog_val,
    input  logic [IDXW-1:0] chk_idx,
    output logic            chk_nz,
    input  logic [IDXW-1:0] sel,
    output logic [CW-1:0]   sel_data
);

    logic [CW-1:0]    slot_q [NSLOT];
    logic [NSLOT-1:0] wr_vec;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign wr_vec[g] = prog_en && (prog_idx == IDXW'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)        slot_q[g] <= '0;
            else if (wr_vec[g]) slot_q[g] <= prog_val;
        end
    end

    always_comb begin
        sel_data = '0;
        chk_nz   = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (sel == IDXW'(i))     sel_data = slot_q[i];
            if (chk_idx == IDXW'(i)) chk_nz   = |slot_q[i];
        end
    end

    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec)); // R4
    AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && sel == prog_idx) |=> (sel_data == $past(prog_val) || sel != $past(sel))); // R5
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= IDXW'(NSLOT)) |-> (sel_data == '0)); // R11

endmodule

// File: rtl/ptr_cfg_seq.sv
module ptr_cfg_seq
    import ptr_cfg_pkg::*;
#(
    parameter int DW        = 16,
    parameter int IDXW      = 4,
    parameter int NPTR      = 5,
    parameter int PTR_BASE  = 8,
    parameter int CTL_IDX   = 14,
    parameter int WSLOT_OFS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [IDXW-1:0]   acc_idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              anomaly,
    input  logic [IDXW-1:0]   cfg_sel,
    output logic [2*DW-1:0]   cfg_data
);

    localparam int CW    = 2 * DW;
    localparam int NSLOT = WSLOT_OFS + NPTR;

    seq_state_t      state_q;
    logic [CW-1:0]   ctl_val;
    logic [DW-1:0]   ctl_rdata;
    logic [DW-1:0]   plain_q;
    logic [IDXW-1:0] ptr_off;
    logic [IDXW-1:0] prog_idx;
    logic            ctl_hit, ptr_hit, consume, rd_slot_nz, mode_drv, plain_acc;

    assign ctl_hit   = acc_en && (acc_idx == IDXW'(CTL_IDX));
    assign ptr_hit   = acc_en && (acc_idx >= IDXW'(PTR_BASE))
                              && (acc_idx <  IDXW'(PTR_BASE + NPTR));
    assign ptr_off   = acc_idx - IDXW'(PTR_BASE);
    assign consume   = ptr_hit && (state_q == ST_ARMED);
    assign mode_drv  = ptr_hit && !consume && rd_slot_nz;
    assign plain_acc = ptr_hit && !consume && !rd_slot_nz;
    assign prog_idx  = acc_wr ? (ptr_off + IDXW'(WSLOT_OFS)) : ptr_off;

    cfg_seq_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_hit  (ctl_hit),
        .ctl_wr   (acc_wr),
        .ctl_wdata(wdata),
        .consume  (consume),
        .state_q  (state_q),
        .ctl_val  (ctl_val),
        .ctl_rdata(ctl_rdata),
        .anomaly  (anomaly)
    );

    cfg_slot_bank #(.CW(CW), .NSLOT(NSLOT), .IDXW(IDXW)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_en (consume),
        .prog_idx(prog_idx),
        .prog_val(ctl_val),
        .chk_idx (ptr_off),
        .chk_nz  (rd_slot_nz),
        .sel     (cfg_sel),
        .sel_data(cfg_data)
    );

    // shared plain pointer word
    always_ff @(posedge clk) begin
        if (!rst_n)                     plain_q <= '0;
        else if (plain_acc && acc_wr)   plain_q <= wdata;
    end

    // read data
    always_comb begin
        rdata = '0;
        if (!acc_wr) begin
            if (ctl_hit)        rdata = ctl_rdata;
            else if (plain_acc) rdata = plain_q;
        end
    end

    AST_PROG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !acc_wr) |-> (rdata == '0)); // R4
    AST_PROG_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && acc_wr) |=> $stable(plain_q)); // R5
    AST_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_drv |=> $stable(plain_q)); // R8
    AST_MODE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_drv && !acc_wr) |-> (rdata == '0)); // R8
    AST_OTHER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !ptr_hit && !ctl_hit) |=> ($stable(plain_q) && $stable(state_q))); // R10

endmodule

// File: tb/sim_ptr_cfg_seq.sv
`timescale 1ns/1ps
module sim_ptr_cfg_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [3:0]  acc_idx = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        anomaly;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    ptr_cfg_seq u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_idx(acc_idx), .wdata(wdata), .rdata(rdata), .anomaly(anomaly),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data)
    );

    // row: {wr, idx[3:0], wdata[15:0], exp_rdata[15:0], exp_anomaly}
    localparam int NV = 26;
    localparam logic [37:0] VEC [0:NV-1] = '{
        {1'b0, 4'd8,  16'h0000, 16'h0000, 1'b0}, // R9 plain read, zero
        {1'b1, 4'd8,  16'h1234, 16'h0000, 1'b0}, // R9
        {1'b0, 4'd10, 16'h0000, 16'h1234, 1'b0}, // R9 shared word
        {1'b1, 4'd12, 16'h5A5A, 16'h0000, 1'b0}, // R9
        {1'b0, 4'd9,  16'h0000, 16'h5A5A, 1'b0}, // R9
        {1'b1, 4'd14, 16'hAAAA, 16'h0000, 1'b0}, // R2 address
        {1'b1, 4'd14, 16'hBBBB, 16'h0000, 1'b0}, // R2 mode, armed
        {1'b0, 4'd9,  16'h0000, 16'h0000, 1'b0}, // R4 program slot 1
        {1'b0, 4'd8,  16'h0000, 16'h5A5A, 1'b0}, // R6 back to plain
        {1'b0, 4'd14, 16'h0000, 16'hAAAA, 1'b0}, // R3 address half
        {1'b0, 4'd14, 16'h0000, 16'hBBBB, 1'b0}, // R3 mode half, armed
        {1'b1, 4'd11, 16'h7777, 16'h0000, 1'b0}, // R5 program slot 9
        {1'b0, 4'd11, 16'h0000, 16'h5A5A, 1'b0}, // R5 plain unchanged
        {1'b1, 4'd14, 16'h1111, 16'h0000, 1'b0}, // R2
        {1'b1, 4'd14, 16'h2222, 16'h0000, 1'b0}, // R2
        {1'b1, 4'd14, 16'h3333, 16'h0000, 1'b1}, // R7 overwrite
        {1'b0, 4'd14, 16'h0000, 16'h3333, 1'b1}, // R7 read while armed
        {1'b1, 4'd8,  16'h9999, 16'h0000, 1'b0}, // R5 program slot 6
        {1'b0, 4'd9,  16'h0000, 16'h0000, 1'b0}, // R8 mode-driven read
        {1'b1, 4'd9,  16'h4444, 16'h0000, 1'b0}, // R8 mode-driven write
        {1'b0, 4'd8,  16'h0000, 16'h5A5A, 1'b0}, // R8 word kept
        {1'b0, 4'd3,  16'h0000, 16'h0000, 1'b0}, // R10
        {1'b1, 4'd3,  16'hFFFF, 16'h0000, 1'b0}, // R10
        {1'b1, 4'd13, 16'h0101, 16'h0000, 1'b0}, // R10
        {1'b0, 4'd13, 16'h0000, 16'h0000, 1'b0}, // R10
        {1'b0, 4'd8,  16'h0000, 16'h5A5A, 1'b0}  // R10 word kept
    };
    localparam int VREQ [0:NV-1] = '{9,9,9,9,9,2,2,4,6,3,3,5,5,2,2,7,7,5,8,8,8,10,10,10,10,10};

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [3:0] idx, input logic [15:0] d,
                       output logic [15:0] rd, output logic an);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_idx = idx; wdata = d;
        #3 rd = rdata;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        an = anomaly;
    endtask

    task automatic slot_is(input string req, input logic [3:0] s, input logic [31:0] exp);
        @(negedge clk);
        cfg_sel = s;
        #1 chk(req, cfg_data, exp);
    endtask

    initial begin
        logic [15:0] rd;
        logic        an;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 anomaly", {31'd0, anomaly}, 32'd0);
        for (int s = 0; s < 16; s++) slot_is("R1 slot", 4'(s), 32'd0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][37], VEC[i][36:33], VEC[i][32:17], rd, an);
            chk($sformatf("R%0d row %0d rdata", VREQ[i], i), {16'd0, rd}, {16'd0, VEC[i][16:1]});
            chk($sformatf("R%0d row %0d anomaly", VREQ[i], i), {31'd0, an}, {31'd0, VEC[i][0]});
        end

        // R11 slot readout, read slots vs write slots at +6
        slot_is("R11 slot1", 4'd1, 32'hAAAABBBB);
        slot_is("R11 slot9", 4'd9, 32'hAAAABBBB);
        slot_is("R11 slot6", 4'd6, 32'h11113333);
        slot_is("R11 slot0", 4'd0, 32'd0);
        slot_is("R11 slot5", 4'd5, 32'd0);
        slot_is("R11 slot15", 4'd15, 32'd0);
        slot_is("R10 slot3 untouched", 4'd3, 32'd0);
        // R6 / R10: sequence restarted and unaffected by stray indices
        acc(1'b0, 4'd14, 16'h0, rd, an);
        chk("R6 ctl address half", {16'd0, rd}, 32'h1111);

        // mid-run reset clears everything (R1)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        slot_is("R1 slot1 cleared", 4'd1, 32'd0);
        acc(1'b0, 4'd9, 16'h0, rd, an);
        chk("R1 plain word cleared", {16'd0, rd}, 32'd0);
        acc(1'b0, 4'd14, 16'h0, rd, an);
        chk("R1 ctl cleared", {16'd0, rd}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got=1 exp=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule